// File: doc/BRIEF.md
# Scatter-Gather DMA Global Register File

This block holds the chip-wide control and status words of a scatter-gather DMA engine behind a 32-bit register bus with word addressing. Software writes it to start a reset of the descriptor prefetcher, let the prefetcher run and arm the watchdog. It also sets the writeback/interrupt pacing delay and the watchdog limit. Software reads it for the version, the build-time configuration, a sticky watchdog error and a live summary of the per-port interrupt lines.

Each register has one of four access kinds. Plain fields are read/write. Two control bits are set by writing 1 and are cleared only by hardware or by reset. The watchdog error bit is cleared by writing 1 to it. Identity and summary words are read-only. Read data is registered. Writes take effect at the clock edge that samples them.

Top module: `dma_gcsr_regs`

## Requirements
- R1: Byte offsets decode as follows: 0x100 control, 0x104 status, 0x108 pacing delay, 0x10C version, 0x114 watchdog limit, 0x118 scratch, 0x11C build parameters, 0x120 port-interrupt summary. `rdata` shows the addressed word from the first clock edge after the edge that samples `rd_en` high, and holds it until the next read.
- R2: Writing 1 to control bit 0 sets `pf_reset_req`. The bit stays set until a cycle with `pf_reset_done` high clears it. Writing 0 has no effect. When a write of 1 and `pf_reset_done` arrive in the same cycle, the bit stays set.
- R3: Writing 1 to control bit 1 sets `pf_run`. Writing 0 leaves it set, and only reset clears it.
- R4: Control bit 2 is a read/write bit driving `wdt_enable`. Control bits 31:3 always read 0.
- R5: Status bit 31 reads as the OR of all `port_irq` lines at the read. Writes to it have no effect.
- R6: Status bit 30 is set by a cycle with `wdt_expired` high and stays set until software writes 1 to it. If that write and `wdt_expired` arrive in the same cycle, the bit stays set. Status bits 29:0 read 0.
- R7: The version word reads 0x00010103: major 1 in bits 23:16, update 1 in bits 15:8, patch 3 in bits 7:0. Writes to it are ignored.
- R8: The build-parameter word packs the following fields: bit 31 unaligned-access enable, bits 30:26 device-to-host stream ports, bits 25:21 host-to-device stream ports, bits 20:16 host-to-device memory ports, bit 6 64-bit address enable, bits 5:4 function mode, bits 1:0 DMA mode. All other bits read 0.
- R9: The summary word carries `port_irq` in its low bits and zeros above. Port i is bit i. The number of ports is the sum of the three port counts, at most 16.
- R10: The scratch word is 32-bit read/write.
- R11: The pacing delay and watchdog limit store bits 19:0 of a write and drive `wb_delay` and `wdt_limit`. Bits 31:20 read 0.
- R12: Any other offset, including any address not a multiple of 4, reads 0. Writes to such offsets change no register.
- R13: After reset, every register and every output reads 0, apart from the constant words and the live interrupt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pf_reset_done | input | 1 | Prefetcher reset-sequence completion pulse |
| wdt_expired | input | 1 | Watchdog expiry pulse |
| port_irq | input | NUM_PORTS | Per-port interrupt levels |
| pf_reset_req | output | 1 | Prefetcher reset request |
| pf_run | output | 1 | Prefetcher fetch enable |
| wdt_enable | output | 1 | Watchdog enable |
| wb_delay | output | 20 | Writeback/interrupt pacing delay |
| wdt_limit | output | 20 | Watchdog limit |

## Verification
A read is due one edge after it is sampled: the bench raises `rd_en` on a falling edge and takes `rdata` on the next falling edge. A write reaches the control outputs, the stored fields and the error flag at the edge that samples it, so the bench checks those outputs on the following falling edge. Hardware pulses on `pf_reset_done` and `wdt_expired` follow the same one-edge rule. For the same-cycle conflicts, the bench raises the pulse on the falling edge where it raises the write. `port_irq` is held steady across each read, so the live bit 31 and the summary word match the value that was on the lines at the sampling edge.

// File: rtl/gcsr_pkg.sv
// Package: shared constants of the DMA global register file.
// Assumes a 32-bit data path and byte addresses aligned to words.
package gcsr_pkg;
    localparam int REG_W    = 32;
    localparam int TMO_W    = 20;
    localparam int NSEL     = 8;
    // Select-vector indices
    localparam int S_CTRL   = 0;
    localparam int S_STAT   = 1;
    localparam int S_PACE   = 2;
    localparam int S_VER    = 3;
    localparam int S_WDOG   = 4;
    localparam int S_SCR    = 5;
    localparam int S_PARAM  = 6;
    localparam int S_IRQSUM = 7;
    // Version fields
    localparam logic [7:0] VER_MAJOR  = 8'd1;
    localparam logic [7:0] VER_UPDATE = 8'd1;
    localparam logic [7:0] VER_PATCH  = 8'd3;

    // Byte offset of each select index
    function automatic logic [11:0] reg_offset(input int idx);
        case (idx)
            S_CTRL:   reg_offset = 12'h100;
            S_STAT:   reg_offset = 12'h104;
            S_PACE:   reg_offset = 12'h108;
            S_VER:    reg_offset = 12'h10C;
            S_WDOG:   reg_offset = 12'h114;
            S_SCR:    reg_offset = 12'h118;
            S_PARAM:  reg_offset = 12'h11C;
            default:  reg_offset = 12'h120;
        endcase
    endfunction
endpackage

// File: rtl/gcsr_decode.sv
// Module: address decoder; raises one select line per implemented word.
// Assumes exact match on the full byte address, so any unaligned or
// unmapped address selects nothing.
module gcsr_decode
    import gcsr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);
    // One comparator per implemented offset
    for (genvar i = 0; i < NSEL; i++) begin : g_cmp
        assign sel[i] = (addr == ADDR_W'(reg_offset(i)));
    end
endmodule

// File: rtl/gcsr_field.sv
// Module: plain read/write field of parameter width.
// Assumes a one-cycle write strobe; resets synchronously to RST_VAL.
module gcsr_field #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    // Store write data when strobed
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wd;
    end
endmodule

// File: rtl/gcsr_ctrl.sv
// Module: control word; bit 0 write-1-to-set with hardware clear,
// bit 1 write-1-to-set cleared only by reset, bit 2 read/write.
// Assumes pf_reset_done is a pulse from the prefetcher.
module gcsr_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] wd,
    input  logic       pf_reset_done,
    output logic       rst_req,
    output logic       run,
    output logic       wdt_en
);
    logic set_rst;
    assign set_rst = we && wd[0];

    // Reset request: software set wins over hardware completion
    always_ff @(posedge clk) begin
        if (!rst_n)             rst_req <= 1'b0;
        else if (set_rst)       rst_req <= 1'b1;
        else if (pf_reset_done) rst_req <= 1'b0;
    end

    // Run enable: sticky until hard reset
    always_ff @(posedge clk) begin
        if (!rst_n)             run <= 1'b0;
        else if (we && wd[1])   run <= 1'b1;
    end

    // Watchdog enable: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)  wdt_en <= 1'b0;
        else if (we) wdt_en <= wd[2];
    end

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !pf_reset_done) |=> rst_req); // R2
    AST_RST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && pf_reset_done && !set_rst) |=> !rst_req); // R2
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run); // R3
endmodule

// File: rtl/gcsr_status.sv
// Module: status word; sticky watchdog error with write-1-to-clear
// (hardware set wins) and live OR of the per-port interrupts.
// Assumes wdt_expired is a pulse and port_irq are level signals.
module gcsr_status #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wdt_expired,
    input  logic [NP-1:0] port_irq,
    output logic          wdt_err,
    output logic          irq_any
);
    // Live interrupt summary
    assign irq_any = |port_irq;

    // Sticky error flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)           wdt_err <= 1'b0;
        else if (wdt_expired) wdt_err <= 1'b1;
        else if (clr)         wdt_err <= 1'b0;
    end

    AST_WDT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |=> wdt_err); // R6
    AST_WDT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wdt_expired) |=> !wdt_err); // R6
    AST_WDT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_err && !clr) |=> wdt_err); // R6
endmodule

// File: rtl/dma_gcsr_regs.sv
// Module: top of the DMA global register file. Decodes the register bus,
// holds the writable fields and returns registered read data.
// Assumes one-cycle rd_en/wr_en strobes and at most 16 ports in total.
module dma_gcsr_regs
    import gcsr_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter bit UNALIGNED_EN = 1'b0,
    parameter int N_D2H_ST     = 2,
    parameter int N_H2D_ST     = 1,
    parameter int N_H2D_MM     = 1,
    parameter bit ADDR64_EN    = 1'b1,
    parameter int FUNC_MODE    = 1,
    parameter int DMA_MODE     = 2,
    localparam int NUM_PORTS   = N_D2H_ST + N_H2D_ST + N_H2D_MM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    input  logic                 pf_reset_done,
    input  logic                 wdt_expired,
    input  logic [NUM_PORTS-1:0] port_irq,
    output logic                 pf_reset_req,
    output logic                 pf_run,
    output logic                 wdt_enable,
    output logic [TMO_W-1:0]     wb_delay,
    output logic [TMO_W-1:0]     wdt_limit
);
    localparam logic [REG_W-1:0] VER_WORD =
        {8'd0, VER_MAJOR, VER_UPDATE, VER_PATCH};
    localparam logic [REG_W-1:0] PARAM_WORD =
        {UNALIGNED_EN, 5'(N_D2H_ST), 5'(N_H2D_ST), 5'(N_H2D_MM),
         9'd0, ADDR64_EN, 2'(FUNC_MODE), 2'd0, 2'(DMA_MODE)};

    logic [NSEL-1:0]  sel;
    logic [NSEL-1:0]  wsel;
    logic             wdt_err;
    logic             irq_any;
    logic [REG_W-1:0] scratch;
    logic [REG_W-1:0] rd_mux;
    logic [15:0]      irq_img;

    gcsr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

    // Write selects qualified by the strobe
    assign wsel = sel & {NSEL{wr_en}};

    gcsr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(wsel[S_CTRL]), .wd(wdata[2:0]),
        .pf_reset_done(pf_reset_done), .rst_req(pf_reset_req),
        .run(pf_run), .wdt_en(wdt_enable)
    );

    gcsr_status #(.NP(NUM_PORTS)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(wsel[S_STAT] && wdata[30]),
        .wdt_expired(wdt_expired), .port_irq(port_irq),
        .wdt_err(wdt_err), .irq_any(irq_any)
    );

    gcsr_field #(.W(TMO_W)) u_pace (
        .clk(clk), .rst_n(rst_n), .we(wsel[S_PACE]),
        .wd(wdata[TMO_W-1:0]), .q(wb_delay)
    );

    gcsr_field #(.W(TMO_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .we(wsel[S_WDOG]),
        .wd(wdata[TMO_W-1:0]), .q(wdt_limit)
    );

    gcsr_field #(.W(REG_W)) u_scr (
        .clk(clk), .rst_n(rst_n), .we(wsel[S_SCR]),
        .wd(wdata), .q(scratch)
    );

    // Per-port interrupt image, zero-extended to 16 bits
    assign irq_img = 16'(port_irq);

    // Read multiplexer over the selected word
    always_comb begin
        rd_mux = '0;
        if (sel[S_CTRL])   rd_mux = {29'd0, wdt_enable, pf_run, pf_reset_req};
        if (sel[S_STAT])   rd_mux = {irq_any, wdt_err, 30'd0};
        if (sel[S_PACE])   rd_mux = {{(REG_W-TMO_W){1'b0}}, wb_delay};
        if (sel[S_VER])    rd_mux = VER_WORD;
        if (sel[S_WDOG])   rd_mux = {{(REG_W-TMO_W){1'b0}}, wdt_limit};
        if (sel[S_SCR])    rd_mux = scratch;
        if (sel[S_PARAM])  rd_mux = PARAM_WORD;
        if (sel[S_IRQSUM]) rd_mux = {16'd0, irq_img};
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R1
    AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel[S_STAT] && (port_irq != '0)) |=> rdata[31]); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == '0)) |=> (rdata == '0)); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R1
endmodule

// File: tb/tb_dma_gcsr_regs.sv
module tb_dma_gcsr_regs;
    localparam int AW = 20;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          pf_reset_done = 1'b0, wdt_expired = 1'b0;
    logic [NP-1:0] port_irq = '0;
    logic          pf_reset_req, pf_run, wdt_enable;
    logic [19:0]   wb_delay, wdt_limit;

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench model
    logic        m_rst = 0, m_run = 0, m_wen = 0, m_err = 0;
    logic [19:0] m_pace = 0, m_wdog = 0;
    logic [31:0] m_scr = 0;

    always #10 clk = ~clk;

    dma_gcsr_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pf_reset_done(pf_reset_done),
        .wdt_expired(wdt_expired), .port_irq(port_irq),
        .pf_reset_req(pf_reset_req), .pf_run(pf_run), .wdt_enable(wdt_enable),
        .wb_delay(wb_delay), .wdt_limit(wdt_limit)
    );

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            20'h100: return {29'd0, m_wen, m_run, m_rst};
            20'h104: return {|port_irq, m_err, 30'd0};
            20'h108: return {12'd0, m_pace};
            20'h10C: return 32'h0001_0103;
            20'h114: return {12'd0, m_wdog};
            20'h118: return m_scr;
            20'h11C: return (32'd2 << 26) | (32'd1 << 21) | (32'd1 << 16)
                            | 32'h40 | (32'd1 << 4) | 32'd2;
            20'h120: return {28'd0, port_irq};
            default: return 32'd0;
        endcase
    endfunction

    function automatic void mdl_write(input logic [AW-1:0] a, input logic [31:0] d);
        case (a)
            20'h100: begin m_rst |= d[0]; m_run |= d[1]; m_wen = d[2]; end
            20'h104: if (d[30]) m_err = 1'b0;
            20'h108: m_pace = d[19:0];
            20'h114: m_wdog = d[19:0];
            20'h118: m_scr = d;
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
        mdl_write(a, d);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a);
        logic [31:0] d;
        do_read(a, d);
        check(req, d, exp_read(a));
    endtask

    task automatic check_outs(input string req);
        check(req, {pf_reset_req, pf_run, wdt_enable}, {m_rst, m_run, m_wen});
        check(req, {wb_delay, wdt_limit}, {m_pace, m_wdog});
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] alist [12];
        void'($urandom(32'h5EED_1234));
        alist = '{20'h100, 20'h104, 20'h108, 20'h10C, 20'h114, 20'h118,
                  20'h11C, 20'h120, 20'h101, 20'h124, 20'h000, 20'h110};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R13: reset state
        check_outs("R13");
        for (int i = 0; i < 12; i++) read_check("R13", alist[i]);

        // R7, R8, R9: constant and live words, writes ignored
        do_write(20'h10C, 32'hFFFF_FFFF);
        read_check("R7", 20'h10C);
        do_write(20'h11C, 32'h0);
        read_check("R8", 20'h11C);
        port_irq = 4'b1010;
        read_check("R9", 20'h120);
        read_check("R5", 20'h104);
        do_write(20'h104, 32'h8000_0000);
        read_check("R5", 20'h104);
        port_irq = '0;
        read_check("R5", 20'h104);

        // R2: set, hold, hardware clear, same-cycle priority
        do_write(20'h100, 32'h1);
        check_outs("R2");
        do_write(20'h100, 32'h0);
        check("R2", pf_reset_req, 1'b1);
        @(negedge clk); wr_en = 1; addr = 20'h100; wdata = 32'h1; pf_reset_done = 1;
        @(negedge clk); wr_en = 0; pf_reset_done = 0;
        check("R2", pf_reset_req, 1'b1);
        pf_reset_done = 1; @(negedge clk); pf_reset_done = 0; m_rst = 0;
        check("R2", pf_reset_req, 1'b0);
        read_check("R2", 20'h100);

        // R3, R4: run sticky, upper control bits zero
        do_write(20'h100, 32'hFFFF_FFFE);
        check_outs("R4");
        read_check("R4", 20'h100);
        do_write(20'h100, 32'h0);
        check("R3", pf_run, 1'b1);
        read_check("R3", 20'h100);

        // R6: sticky error, W1C, same-cycle priority
        wdt_expired = 1; @(negedge clk); wdt_expired = 0; m_err = 1;
        read_check("R6", 20'h104);
        do_write(20'h104, 32'h3FFF_FFFF);
        read_check("R6", 20'h104);
        @(negedge clk); wr_en = 1; addr = 20'h104; wdata = 32'h4000_0000; wdt_expired = 1;
        @(negedge clk); wr_en = 0; wdt_expired = 0;
        read_check("R6", 20'h104);
        do_write(20'h104, 32'h4000_0000);
        read_check("R6", 20'h104);

        // R11, R10, R12 directed
        do_write(20'h108, 32'hFFFF_FFFF);
        read_check("R11", 20'h108);
        do_write(20'h114, 32'hABCD_E123);
        check_outs("R11");
        read_check("R11", 20'h114);
        do_write(20'h118, 32'hDEAD_BEEF);
        read_check("R10", 20'h118);
        do_write(20'h119, 32'h1234_5678);
        do_write(20'h124, 32'h1234_5678);
        read_check("R12", 20'h118);
        read_check("R12", 20'h119);

        // Random mix; reset-done and expiry stay low here
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = alist[$urandom_range(0, 11)];
            port_irq = NP'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                do_write(a, $urandom);
                check_outs("R10");
            end else begin
                read_check("R1", a);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule